// File: doc/BRIEF.md
# Fetch Packet Issue-Group Splitter

This block sits between an instruction fetch stage and a dispatch stage. Fetch delivers one wide packet of eight 32-bit instruction words. Within a packet, instructions are chained into issue groups by a per-instruction parallel flag. The splitter holds the packet and emits one issue group per clock to dispatch. It stalls fetch until the last group of the held packet goes out. A packet whose instructions all chain together leaves in a single cycle. A packet with no chaining takes eight cycles, and this opens bubbles in the fetch stream.

Each issue group is packed to the low output lanes. Lane k carries the instruction from slot (start + k) of the packet, together with that slot number. A lane mask marks the occupied lanes, and unused lanes are driven to zero. A last flag marks the group that finishes the packet.

Control is a two-state machine. In SPL_EMPTY no packet is held and fetch is always accepted. In SPL_ISSUE a packet is held and a slot pointer marks where the next group starts. The transitions are:
- EMPTY_LOAD: SPL_EMPTY to SPL_ISSUE when a packet is offered.
- ADVANCE: SPL_ISSUE to SPL_ISSUE when a non-final group goes out and the pointer moves past it.
- RELOAD: SPL_ISSUE to SPL_ISSUE when the final group goes out and a new packet is taken in the same cycle.
- DRAIN: SPL_ISSUE to SPL_EMPTY when the final group goes out and nothing is offered.

Top module: `fp_splitter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: When no packet is held, `out_valid` is 0 and `in_ready` is 1.
- R3: An issue group starts at the current slot and takes in each following slot as long as bit 0 of the previous instruction word is 1. The group ends at the first slot whose bit 0 is 0. `out_mask` has ones in exactly the low `count` bits.
- R4: Slot 7 always ends a group, whatever its bit 0 holds. A packet whose eight words all have bit 0 set leaves as one group of eight.
- R5: Lane k of `out_words` (bits 32k+31..32k) carries the word from slot start+k. Lane k of `out_slot_idx` (bits 3k+2..3k) carries start+k. Every lane outside the mask is zero in both outputs.
- R6: `in_ready` is 1 while a packet is held only in the cycle that emits that packet's final group.
- R7: `out_last` is 1 exactly on the group that contains slot 7.
- R8: A packet accepted at a clock edge produces its first group in the cycle right after that edge. Back-to-back single-group packets therefore flow at one per cycle with no bubble.
- R9: The groups of a packet come out on consecutive cycles, in slot order, and cover every slot exactly once.
- R10: A packet offered while `in_ready` is 0 is not taken. The groups still to be emitted from the held packet are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch offers a packet |
| in_ready | output | 1 | Splitter takes the offered packet at this edge |
| in_packet | input | 256 | Eight instruction words, slot s in bits 32s+31..32s |
| out_valid | output | 1 | An issue group is presented this cycle |
| out_mask | output | 8 | Occupied output lanes, packed low |
| out_words | output | 256 | Instruction words packed to the low lanes |
| out_slot_idx | output | 24 | Source slot of each lane, 3 bits per lane |
| out_last | output | 1 | This group finishes the held packet |

## Verification
`in_ready` depends only on registered state, so it is valid in the same cycle as the group being shown. A packet accepted at an edge shows its first group one cycle later, and each further group follows one cycle after the previous one. The bench drives inputs and samples just after the falling edge. At each sample it compares the head of a queue of expected groups against the outputs and `in_ready`. It then appends the groups of any packet that the handshake accepted in that cycle, so each expected group lines up with the cycle in which it is due.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int unsigned FP_SLOTS   = 8;
    localparam int unsigned FP_WORD_W  = 32;
    localparam int unsigned FP_PAR_BIT = 0;

    typedef enum logic {
        SPL_EMPTY = 1'b0,
        SPL_ISSUE = 1'b1
    } spl_state_e;
endpackage

// File: rtl/fps_group_end.sv
module fps_group_end #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] par_flags,
    input  logic [IDX_W-1:0] start,
    output logic [IDX_W-1:0] end_slot,
    output logic [IDX_W:0]   count,
    output logic             final_grp
);
    // Lowest slot at or after start whose chain flag is clear, or the top slot.
    always_comb begin
        end_slot = IDX_W'(SLOTS - 1);
        for (int j = SLOTS - 1; j >= 0; j--) begin
            if ((IDX_W'(j) >= start) &&
                ((j == SLOTS - 1) || !par_flags[j])) begin
                end_slot = IDX_W'(j);
            end
        end
    end

    always_comb begin
        count     = {1'b0, end_slot} - {1'b0, start} + (IDX_W+1)'(1);
        final_grp = (end_slot == IDX_W'(SLOTS - 1));
    end
endmodule

// File: rtl/fps_lane_pack.sv
module fps_lane_pack #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned PKT_W = SLOTS * WORD_W
) (
    input  logic [PKT_W-1:0]       pkt,
    input  logic [IDX_W-1:0]       start,
    input  logic [IDX_W:0]         count,
    input  logic                   enable,
    output logic [SLOTS-1:0]       lane_mask,
    output logic [PKT_W-1:0]       lane_words,
    output logic [SLOTS*IDX_W-1:0] lane_idx
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_lane
        logic [IDX_W:0] src;
        logic           used;

        always_comb begin
            src  = {1'b0, start} + (IDX_W+1)'(k);
            used = enable && ((IDX_W+1)'(k) < count);
        end

        always_comb begin
            lane_mask[k] = used;
            if (used) begin
                lane_words[k*WORD_W +: WORD_W] = pkt[src[IDX_W-1:0]*WORD_W +: WORD_W];
                lane_idx[k*IDX_W +: IDX_W]     = src[IDX_W-1:0];
            end else begin
                lane_words[k*WORD_W +: WORD_W] = '0;
                lane_idx[k*IDX_W +: IDX_W]     = '0;
            end
        end
    end
endmodule

// File: rtl/fp_splitter.sv
module fp_splitter
    import fps_pkg::*;
#(
    parameter int unsigned SLOTS   = FP_SLOTS,
    parameter int unsigned WORD_W  = FP_WORD_W,
    parameter int unsigned PAR_BIT = FP_PAR_BIT,
    localparam int unsigned IDX_W  = $clog2(SLOTS),
    localparam int unsigned PKT_W  = SLOTS * WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [PKT_W-1:0]       in_packet,
    output logic                   out_valid,
    output logic [SLOTS-1:0]       out_mask,
    output logic [PKT_W-1:0]       out_words,
    output logic [SLOTS*IDX_W-1:0] out_slot_idx,
    output logic                   out_last
);
    spl_state_e       state_q, state_d;
    logic [PKT_W-1:0] hold_q;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             load;

    logic [SLOTS-1:0] par_flags;
    logic [IDX_W-1:0] grp_end;
    logic [IDX_W:0]   grp_count;
    logic             grp_final;
    logic             issuing;

    for (genvar s = 0; s < SLOTS; s++) begin : g_par
        assign par_flags[s] = hold_q[s*WORD_W + PAR_BIT];
    end

    fps_group_end #(.SLOTS(SLOTS)) u_end (
        .par_flags (par_flags),
        .start     (ptr_q),
        .end_slot  (grp_end),
        .count     (grp_count),
        .final_grp (grp_final)
    );

    assign issuing = (state_q == SPL_ISSUE);

    fps_lane_pack #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_pack (
        .pkt        (hold_q),
        .start      (ptr_q),
        .count      (grp_count),
        .enable     (issuing),
        .lane_mask  (out_mask),
        .lane_words (out_words),
        .lane_idx   (out_slot_idx)
    );

    // State register, held packet and slot pointer.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPL_EMPTY;
            ptr_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (load) hold_q <= in_packet;
        end
    end

    // Next-state: EMPTY_LOAD, ADVANCE, RELOAD, DRAIN.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        load    = 1'b0;
        unique case (state_q)
            SPL_EMPTY: begin
                if (in_valid) begin
                    load    = 1'b1;
                    ptr_d   = '0;
                    state_d = SPL_ISSUE;
                end
            end
            SPL_ISSUE: begin
                if (grp_final) begin
                    ptr_d = '0;
                    if (in_valid) begin
                        load    = 1'b1;
                        state_d = SPL_ISSUE;
                    end else begin
                        state_d = SPL_EMPTY;
                    end
                end else begin
                    ptr_d = grp_end + IDX_W'(1);
                end
            end
            default: begin
                state_d = SPL_EMPTY;
                ptr_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            SPL_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                out_last  = 1'b0;
            end
            SPL_ISSUE: begin
                in_ready  = grp_final;
                out_valid = 1'b1;
                out_last  = grp_final;
            end
            default: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                out_last  = 1'b0;
            end
        endcase
    end

    logic [IDX_W+1:0] reach;
    assign reach = (IDX_W+2)'(out_slot_idx[IDX_W-1:0]) + (IDX_W+2)'($countones(out_mask));

    // R2
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R6
    stall_mid_packet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !in_ready);

    // R3
    mask_packed_low_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_mask != '0) && ((out_mask & (out_mask + SLOTS'(1))) == '0)));

    // R7
    last_reaches_top_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (reach == (IDX_W+2)'(SLOTS))));

    // R8
    accept_then_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R9
    groups_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_valid &&
            ((IDX_W+2)'(out_slot_idx[IDX_W-1:0]) == $past(reach))));
endmodule

// File: tb/fp_splitter_tb.sv
module fp_splitter_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] in_packet;
    logic         out_valid;
    logic [7:0]   out_mask;
    logic [255:0] out_words;
    logic [23:0]  out_slot_idx;
    logic         out_last;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic [7:0]   mask;
        logic [255:0] words;
        logic [23:0]  idx;
        logic         last;
    } grp_t;

    grp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_splitter u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_packet    (in_packet),
        .out_valid    (out_valid),
        .out_mask     (out_mask),
        .out_words    (out_words),
        .out_slot_idx (out_slot_idx),
        .out_last     (out_last)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected groups of one packet, from the chaining rule of R3/R4/R5/R7.
    task automatic push_groups(input logic [255:0] p);
        int s = 0;
        while (s < 8) begin
            int e = s;
            grp_t g;
            while (e < 7 && p[e*32]) e++;
            g = '0;
            for (int k = 0; k <= e - s; k++) begin
                g.mask[k]            = 1'b1;
                g.words[k*32 +: 32]  = p[(s+k)*32 +: 32];
                g.idx[k*3 +: 3]      = 3'(s + k);
            end
            g.last = (e == 7);
            expq.push_back(g);
            s = e + 1;
        end
    endtask

    task automatic step(input logic v, input logic [255:0] p);
        @(negedge clk);
        in_valid  = v;
        in_packet = p;
        #1;
        if (expq.size() == 0) begin
            chk("R2", "out_valid idle", 256'(out_valid), 256'(0));
            chk("R2", "in_ready idle", 256'(in_ready), 256'(1));
        end else begin
            grp_t g = expq.pop_front();
            chk("R8/R9", "out_valid", 256'(out_valid), 256'(1));
            chk("R3/R4", "out_mask", 256'(out_mask), 256'(g.mask));
            chk("R5/R10", "out_words", out_words, g.words);
            chk("R5", "out_slot_idx", 256'(out_slot_idx), 256'(g.idx));
            chk("R7", "out_last", 256'(out_last), 256'(g.last));
            chk("R6", "in_ready held", 256'(in_ready), 256'(g.last));
        end
        if (v && in_ready) push_groups(p);
    endtask

    function automatic logic [255:0] make_pkt(input logic [7:0] flags);
        logic [255:0] p;
        for (int k = 0; k < 8; k++) begin
            p[k*32 +: 32] = $urandom();
            p[k*32]       = flags[k];
        end
        return p;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        in_valid = 1'b0;
        in_packet = '0;
        repeat (2) @(negedge clk);
        #1;
        // R1: during reset
        chk("R1", "out_valid in reset", 256'(out_valid), 256'(0));
        chk("R1", "in_ready in reset", 256'(in_ready), 256'(1));
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "out_valid after reset", 256'(out_valid), 256'(0));
        chk("R1", "in_ready after reset", 256'(in_ready), 256'(1));

        // R4: all chain flags set, including slot 7 -> one group of eight
        step(1'b1, make_pkt(8'hFF));
        step(1'b0, '0);
        // R3: no chaining -> eight single groups; R10: offers during stall
        step(1'b1, make_pkt(8'h00));
        for (int i = 0; i < 8; i++) step(1'b1, make_pkt(8'($urandom())));
        for (int i = 0; i < 12; i++) step(1'b0, '0);
        // Mixed chain patterns
        step(1'b1, make_pkt(8'h55));
        for (int i = 0; i < 6; i++) step(1'b0, '0);
        step(1'b1, make_pkt(8'h7E));
        for (int i = 0; i < 4; i++) step(1'b0, '0);
        step(1'b1, make_pkt(8'h80));
        for (int i = 0; i < 9; i++) step(1'b0, '0);
        // R8: back-to-back single-group packets, no bubble
        for (int i = 0; i < 10; i++) step(1'b1, make_pkt(8'h7F));
        for (int i = 0; i < 3; i++) step(1'b0, '0);

        // Random traffic, chain flag set with probability 3/4
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] f;
            for (int k = 0; k < 8; k++) f[k] = ($urandom_range(3) != 0);
            step($urandom_range(9) < 7, make_pkt(f));
        end
        for (int i = 0; i < 12; i++) step(1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule